// File: doc/BRIEF.md
# Boundary Scan Register Chain with Tristate Group Control

This block is a compact boundary scan register chain placed between a chip's pins and its core logic. It mixes three kinds of cell in one serial path. Observe-only cells sit on input pins. Output cells, each with an update latch, sit on two-state outputs and on the data half of a bidirectional bus. A single control cell owns the output enable of the whole bus. A TAP controller outside the block supplies select, capture, shift, update and the active instruction, coded as a two-bit mode.

In functional mode, core values pass straight to the pins. Under the external-test and clamp instructions, the pins and the bus enable are driven from the update latches instead. Under the high-impedance instruction, the bus driver is forced off. Pin values always reach the core unchanged. Shifting moves data through the shift stages only, so a new pattern can be loaded while the pins keep their present values. The pins change only on an update strobe.

Top module: `bsr_chain`

## Requirements
- R1: While `rst_ni` is low, and after it rises, every shift stage is 0. The control-cell latch is 1 (bus driver disabled). Each two-state output latch holds its bit of `OUT_SAFE` (default 2'b01). Every bus data latch is 0.
- R2: With `mode_i` = 2'b00 (functional), `pin_out_o` equals `core_out_i`, `bus_o` equals `core_bus_i` and `bus_oe_o` equals `core_bus_oe_i`. In every mode, `core_in_o` equals `pin_in_i` and `core_bus_o` equals `bus_i`.
- R3: With `mode_i` = 2'b01 (external test), `pin_out_o` and `bus_o` come from their update latches, and `bus_oe_o` is the inverse of the control latch (a latched 1 disables the driver).
- R4: With `mode_i` = 2'b10 (clamp), the pins and the bus enable take their values from the update latches, exactly as in R3.
- R5: With `mode_i` = 2'b11 (high impedance), `bus_oe_o` is 0 whatever the control latch or `core_bus_oe_i` holds, and the data pins follow the core.
- R6: The chain has N_IN+N_OUT+1+2*N_BUS cells (23 by default). On each edge with `select_i` and `shift_i` high (and `capture_i` low), every stage takes the value of its neighbour on the TDI side. The top cell takes `tdi_i`, and `tdo_o` shows cell 0. A bit therefore reaches `tdo_o` after exactly as many shifts as the chain is long.
- R7: Cells are numbered from `tdo_o`. Cells 0..N_IN-1 observe `pin_in_i`. The next N_OUT cells are two-state outputs. Then comes the control cell. Then, for bus bit k, the output cell sits at CTL+1+2k and the observe cell at CTL+2+2k. On an edge with `select_i` and `capture_i` high (capture wins over shift), each cell loads what it sees: input pins, the value actually driven on each output, the driven disable value for the control cell, and `bus_i` for bus observe cells.
- R8: Update latches change only on an edge with `select_i` and `update_i` high. Shifting and capturing leave `pin_out_o`, `bus_o` and `bus_oe_o` unchanged.
- R9: With `select_i` low, capture, shift and update have no effect on the shift stages or the latches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| select_i | input | 1 | Boundary register selected by the current instruction |
| capture_i | input | 1 | Capture strobe |
| shift_i | input | 1 | Shift strobe |
| update_i | input | 1 | Update strobe |
| mode_i | input | 2 | 00 functional, 01 external test, 10 clamp, 11 high impedance |
| tdi_i | input | 1 | Serial input at the top of the chain |
| tdo_o | output | 1 | Serial output, cell 0 |
| pin_in_i | input | N_IN | Input pins |
| core_in_o | output | N_IN | Input pin values to the core |
| core_out_i | input | N_OUT | Core values for the two-state outputs |
| pin_out_o | output | N_OUT | Two-state output pins |
| core_bus_i | input | N_BUS | Core data for the bidirectional bus |
| core_bus_oe_i | input | 1 | Core bus drive enable, active high |
| bus_o | output | N_BUS | Bus data driven toward the pads |
| bus_oe_o | output | 1 | Bus pad driver enable, active high |
| bus_i | input | N_BUS | Bus values seen at the pads |
| core_bus_o | output | N_BUS | Bus pad values to the core |

## Verification
The pin outputs are combinational from the mode, the core inputs and the update latches. A mode or core change is therefore due in the same cycle, and a new latch value appears just after the update edge. The shift stage at cell 0 appears on `tdo_o` right after each capture or shift edge. The bench drives inputs one nanosecond after the rising edge. It advances its behavioural model on the rising edge and compares every output at the falling edge, half a cycle after the last register that could move. Serial read-outs sample `tdo_o` just after each edge, before the next shift.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  typedef enum logic [1:0] {
    MODE_FUNC   = 2'b00,
    MODE_EXTEST = 2'b01,
    MODE_CLAMP  = 2'b10,
    MODE_HIGHZ  = 2'b11
  } bsr_mode_e;

  function automatic logic latch_drives(bsr_mode_e m);
    return (m == MODE_EXTEST) || (m == MODE_CLAMP);
  endfunction
endpackage

// File: rtl/bsr_cell.sv
module bsr_cell #(
  parameter bit HAS_UPDATE = 1'b1,
  parameter bit RST_VAL    = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic capture_i,
  input  logic shift_i,
  input  logic update_i,
  input  logic cap_i,
  input  logic ser_i,
  output logic ser_o,
  output logic upd_o
);
  logic sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sr_q <= 1'b0;
    else if (capture_i) sr_q <= cap_i;
    else if (shift_i)   sr_q <= ser_i;
  end

  assign ser_o = sr_q;

  // R6: one shift edge moves the neighbour's value in
  a_r6_shift_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !capture_i) |=> (ser_o == $past(ser_i)));

  generate
    if (HAS_UPDATE) begin : g_upd
      logic upd_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       upd_q <= RST_VAL;
        else if (update_i) upd_q <= sr_q;
      end
      assign upd_o = upd_q;

      // R8: latch moves only on the update strobe
      a_r8_latch_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !update_i |=> $stable(upd_o));
    end else begin : g_obs
      logic unused_update;
      assign unused_update = update_i;
      assign upd_o = RST_VAL;
    end
  endgenerate
endmodule

// File: rtl/bsr_pin_mux.sv
module bsr_pin_mux
  import bsr_pkg::*;
#(
  parameter int unsigned W = 1
) (
  input  bsr_mode_e      mode_i,
  input  logic [W-1:0]   core_i,
  input  logic [W-1:0]   latch_i,
  output logic [W-1:0]   pin_o
);
  assign pin_o = latch_drives(mode_i) ? latch_i : core_i;
endmodule

// File: rtl/bsr_chain.sv
module bsr_chain
  import bsr_pkg::*;
#(
  parameter int unsigned    N_IN     = 4,
  parameter int unsigned    N_OUT    = 2,
  parameter int unsigned    N_BUS    = 8,
  parameter logic [N_OUT-1:0] OUT_SAFE = 2'b01
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             select_i,
  input  logic             capture_i,
  input  logic             shift_i,
  input  logic             update_i,
  input  logic [1:0]       mode_i,
  input  logic             tdi_i,
  output logic             tdo_o,
  input  logic [N_IN-1:0]  pin_in_i,
  output logic [N_IN-1:0]  core_in_o,
  input  logic [N_OUT-1:0] core_out_i,
  output logic [N_OUT-1:0] pin_out_o,
  input  logic [N_BUS-1:0] core_bus_i,
  input  logic             core_bus_oe_i,
  output logic [N_BUS-1:0] bus_o,
  output logic             bus_oe_o,
  input  logic [N_BUS-1:0] bus_i,
  output logic [N_BUS-1:0] core_bus_o
);
  localparam int unsigned CTL_IDX   = N_IN + N_OUT;
  localparam int unsigned BUS_BASE  = CTL_IDX + 1;
  localparam int unsigned CHAIN_LEN = BUS_BASE + 2 * N_BUS;

  bsr_mode_e mode;
  assign mode = bsr_mode_e'(mode_i);

  logic cap_en, shift_en, upd_en;
  assign cap_en   = select_i & capture_i;
  assign shift_en = select_i & shift_i;
  assign upd_en   = select_i & update_i;

  logic [CHAIN_LEN-1:0] cap_v, ser_q, ser_in, upd_v;
  logic [N_OUT-1:0]     out_lat;
  logic [N_BUS-1:0]     bus_lat;
  logic                 ctl_lat, ctl_dis;

  assign ser_in = {tdi_i, ser_q[CHAIN_LEN-1:1]};
  assign tdo_o  = ser_q[0];

  generate
    for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_cell
      if (i < N_IN) begin : g_in
        assign cap_v[i] = pin_in_i[i];
        bsr_cell #(.HAS_UPDATE(1'b0), .RST_VAL(1'b0)) u_cell (
          .clk_i, .rst_ni, .capture_i(cap_en), .shift_i(shift_en), .update_i(upd_en),
          .cap_i(cap_v[i]), .ser_i(ser_in[i]), .ser_o(ser_q[i]), .upd_o(upd_v[i]));
      end else if (i < CTL_IDX) begin : g_out
        assign cap_v[i]       = pin_out_o[i-N_IN];
        assign out_lat[i-N_IN] = upd_v[i];
        bsr_cell #(.HAS_UPDATE(1'b1), .RST_VAL(OUT_SAFE[i-N_IN])) u_cell (
          .clk_i, .rst_ni, .capture_i(cap_en), .shift_i(shift_en), .update_i(upd_en),
          .cap_i(cap_v[i]), .ser_i(ser_in[i]), .ser_o(ser_q[i]), .upd_o(upd_v[i]));
      end else if (i == CTL_IDX) begin : g_ctl
        assign cap_v[i] = ctl_dis;
        assign ctl_lat  = upd_v[i];
        bsr_cell #(.HAS_UPDATE(1'b1), .RST_VAL(1'b1)) u_cell (
          .clk_i, .rst_ni, .capture_i(cap_en), .shift_i(shift_en), .update_i(upd_en),
          .cap_i(cap_v[i]), .ser_i(ser_in[i]), .ser_o(ser_q[i]), .upd_o(upd_v[i]));
      end else if (((i - BUS_BASE) % 2) == 0) begin : g_bus_out
        assign cap_v[i]                 = bus_o[(i-BUS_BASE)/2];
        assign bus_lat[(i-BUS_BASE)/2]  = upd_v[i];
        bsr_cell #(.HAS_UPDATE(1'b1), .RST_VAL(1'b0)) u_cell (
          .clk_i, .rst_ni, .capture_i(cap_en), .shift_i(shift_en), .update_i(upd_en),
          .cap_i(cap_v[i]), .ser_i(ser_in[i]), .ser_o(ser_q[i]), .upd_o(upd_v[i]));
      end else begin : g_bus_obs
        assign cap_v[i] = bus_i[(i-BUS_BASE)/2];
        bsr_cell #(.HAS_UPDATE(1'b0), .RST_VAL(1'b0)) u_cell (
          .clk_i, .rst_ni, .capture_i(cap_en), .shift_i(shift_en), .update_i(upd_en),
          .cap_i(cap_v[i]), .ser_i(ser_in[i]), .ser_o(ser_q[i]), .upd_o(upd_v[i]));
      end
    end
  endgenerate

  logic unused_obs;
  assign unused_obs = ^upd_v;

  bsr_pin_mux #(.W(N_OUT)) u_out_mux (
    .mode_i(mode), .core_i(core_out_i), .latch_i(out_lat), .pin_o(pin_out_o));

  bsr_pin_mux #(.W(N_BUS)) u_bus_mux (
    .mode_i(mode), .core_i(core_bus_i), .latch_i(bus_lat), .pin_o(bus_o));

  // control path carries the disable sense: 1 = driver off
  always_comb begin
    if (mode == MODE_HIGHZ)     ctl_dis = 1'b1;
    else if (latch_drives(mode)) ctl_dis = ctl_lat;
    else                        ctl_dis = ~core_bus_oe_i;
  end
  assign bus_oe_o = ~ctl_dis;

  assign core_in_o  = pin_in_i;
  assign core_bus_o = bus_i;

  // R5: high impedance keeps the bus driver off
  a_r5_highz_oe_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_HIGHZ) |-> !bus_oe_o);

  // R8: latch-driven pins hold unless an update edge occurs
  a_r8_pins_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_drives(mode) && !upd_en) |=>
      (!latch_drives(mode) || ($stable(pin_out_o) && $stable(bus_o) && $stable(bus_oe_o))));
endmodule

// File: tb/bsr_chain_test.sv
`timescale 1ns/1ps
module bsr_chain_test;
  localparam int NI  = 4;
  localparam int NO  = 2;
  localparam int NB  = 8;
  localparam int CTL = NI + NO;
  localparam int BB  = CTL + 1;
  localparam int L   = BB + 2 * NB;
  localparam logic [NO-1:0] SAFE = 2'b01;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, cap = 1'b0, sh = 1'b0, upd = 1'b0, tdi = 1'b0;
  logic [1:0] mode = 2'b01;
  logic [NI-1:0] pin_in = '0;
  logic [NO-1:0] core_out = '0;
  logic [NB-1:0] core_bus = '0, bus_in = '0;
  logic core_oe = 1'b0;

  logic tdo, bus_oe;
  logic [NI-1:0] core_in;
  logic [NO-1:0] pin_out;
  logic [NB-1:0] bus_o, core_bus_o;

  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  bsr_chain #(.N_IN(NI), .N_OUT(NO), .N_BUS(NB), .OUT_SAFE(SAFE)) uut (
    .clk_i(clk), .rst_ni(rst_n), .select_i(sel), .capture_i(cap), .shift_i(sh),
    .update_i(upd), .mode_i(mode), .tdi_i(tdi), .tdo_o(tdo),
    .pin_in_i(pin_in), .core_in_o(core_in), .core_out_i(core_out), .pin_out_o(pin_out),
    .core_bus_i(core_bus), .core_bus_oe_i(core_oe), .bus_o(bus_o), .bus_oe_o(bus_oe),
    .bus_i(bus_in), .core_bus_o(core_bus_o));

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural model
  bit msr[L];
  bit mlat[L];

  function automatic bit from_lat();
    return (mode == 2'b01) || (mode == 2'b10);
  endfunction
  function automatic bit has_latch(int i);
    return (i >= NI) && ((i <= CTL) || (((i - BB) % 2) == 0));
  endfunction
  function automatic bit m_out(int j);
    return from_lat() ? mlat[NI+j] : core_out[j];
  endfunction
  function automatic bit m_bus(int k);
    return from_lat() ? mlat[BB+2*k] : core_bus[k];
  endfunction
  function automatic bit m_dis();
    if (mode == 2'b11) return 1'b1;
    return from_lat() ? mlat[CTL] : !core_oe;
  endfunction
  function automatic bit m_cap(int i);
    if (i < NI) return pin_in[i];
    if (i < CTL) return m_out(i - NI);
    if (i == CTL) return m_dis();
    if (((i - BB) % 2) == 0) return m_bus((i - BB) / 2);
    return bus_in[(i - BB) / 2];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < L; i++) begin
        msr[i]  = 1'b0;
        mlat[i] = 1'b0;
      end
      for (int j = 0; j < NO; j++) mlat[NI+j] = SAFE[j];
      mlat[CTL] = 1'b1;
    end else begin
      bit nsr[L];
      for (int i = 0; i < L; i++) begin
        if (sel && cap)     nsr[i] = m_cap(i);
        else if (sel && sh) nsr[i] = (i == L - 1) ? tdi : msr[i+1];
        else                nsr[i] = msr[i];
      end
      if (sel && upd)
        for (int i = 0; i < L; i++) if (has_latch(i)) mlat[i] = msr[i];
      for (int i = 0; i < L; i++) msr[i] = nsr[i];
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    logic [NO-1:0] eo;
    logic [NB-1:0] eb;
    string tg;
    for (int j = 0; j < NO; j++) eo[j] = m_out(j);
    for (int k = 0; k < NB; k++) eb[k] = m_bus(k);
    case (mode)
      2'b00: tg = "R2";
      2'b01: tg = "R3";
      2'b10: tg = "R4";
      default: tg = "R5";
    endcase
    check(tdo === msr[0], "R6 tdo", 32'(tdo), 32'(msr[0]));
    check(pin_out === eo, {tg, " pin_out"}, 32'(pin_out), 32'(eo));
    check(bus_o === eb, {tg, " bus_o"}, 32'(bus_o), 32'(eb));
    check(bus_oe === !m_dis(), {tg, " bus_oe"}, 32'(bus_oe), 32'(!m_dis()));
    check(core_in === pin_in, "R2 core_in", 32'(core_in), 32'(pin_in));
    check(core_bus_o === bus_in, "R2 core_bus", 32'(core_bus_o), 32'(bus_in));
  end

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic xchg(input logic [L-1:0] vin, output logic [L-1:0] vout);
    for (int t = 0; t < L; t++) begin
      vout[t] = tdo;
      tdi = vin[t];
      sh = 1'b1;
      cyc();
    end
    sh = 1'b0;
  endtask

  task automatic pulse_update();
    upd = 1'b1;
    cyc();
    upd = 1'b0;
  endtask

  function automatic logic [NB-1:0] bus_of(logic [L-1:0] v);
    logic [NB-1:0] b;
    for (int k = 0; k < NB; k++) b[k] = v[BB+2*k];
    return b;
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [L-1:0] pat_a, pat_b, rd, ecap;
    pat_a = 23'h5A3C96;
    pat_b = 23'h2C5F4B;
    repeat (3) cyc();
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset latch values visible through EXTEST
    check(bus_oe === 1'b0, "R1 ctl latch", 32'(bus_oe), 32'h0);
    check(pin_out === SAFE, "R1 out latch", 32'(pin_out), 32'(SAFE));
    check(bus_o === '0, "R1 bus latch", 32'(bus_o), 32'h0);
    check(tdo === 1'b0, "R1 shift stage", 32'(tdo), 32'h0);
    cyc();

    // R2: functional pass-through under varied data
    mode = 2'b00;
    for (int n = 0; n < 8; n++) begin
      core_out = NO'($urandom); core_bus = NB'($urandom); core_oe = 1'($urandom);
      pin_in = NI'($urandom); bus_in = NB'($urandom);
      cyc();
    end
    @(negedge clk);
    check(bus_o === core_bus, "R2 bus follows core", 32'(bus_o), 32'(core_bus));
    cyc();

    // R3/R8: load pattern A, pins unchanged until update
    mode = 2'b01;
    sel = 1'b1;
    xchg(pat_a, rd);
    @(negedge clk);
    check(bus_o === '0 && pin_out === SAFE && bus_oe === 1'b0, "R8 shift keeps pins",
          32'({bus_oe, pin_out, bus_o}), 32'({1'b0, SAFE, NB'(0)}));
    cyc();
    pulse_update();
    @(negedge clk);
    check(bus_o === bus_of(pat_a), "R3 bus from latch", 32'(bus_o), 32'(bus_of(pat_a)));
    check(pin_out === pat_a[CTL-1:NI], "R3 out from latch", 32'(pin_out), 32'(pat_a[CTL-1:NI]));
    check(bus_oe === !pat_a[CTL], "R3 enable from ctl", 32'(bus_oe), 32'(!pat_a[CTL]));
    core_bus = ~core_bus;
    cyc();

    // R6: pattern A leaves on tdo in order while B enters
    xchg(pat_b, rd);
    check(rd === pat_a, "R6 chain length and order", 32'(rd), 32'(pat_a));
    @(negedge clk);
    check(bus_o === bus_of(pat_a), "R8 pins hold during shift", 32'(bus_o), 32'(bus_of(pat_a)));
    cyc();

    // R4: clamp drives from latches
    mode = 2'b10;
    pulse_update();
    @(negedge clk);
    check(bus_o === bus_of(pat_b), "R4 clamp bus", 32'(bus_o), 32'(bus_of(pat_b)));
    check(bus_oe === 1'b0, "R4 clamp enable", 32'(bus_oe), 32'h0);
    cyc();

    // R5: latch enables the driver, HIGHZ still forces it off
    xchg(pat_a, rd);
    pulse_update();
    mode = 2'b11;
    core_oe = 1'b1;
    cyc();
    @(negedge clk);
    check(bus_oe === 1'b0, "R5 forced off", 32'(bus_oe), 32'h0);
    check(bus_o === core_bus, "R5 data from core", 32'(bus_o), 32'(core_bus));
    cyc();

    // R7: capture in functional mode
    mode = 2'b00;
    pin_in = 4'hA; core_out = 2'b10; core_bus = 8'hC3; core_oe = 1'b1; bus_in = 8'h5E;
    cap = 1'b1;
    cyc();
    cap = 1'b0;
    ecap = '0;
    ecap[NI-1:0] = pin_in;
    ecap[CTL-1:NI] = core_out;
    ecap[CTL] = !core_oe;
    for (int k = 0; k < NB; k++) begin
      ecap[BB+2*k]   = core_bus[k];
      ecap[BB+2*k+1] = bus_in[k];
    end

    // R9: strobes with select low are ignored
    sel = 1'b0;
    sh = 1'b1;
    repeat (5) cyc();
    sh = 1'b0;
    pin_in = ~pin_in; bus_in = ~bus_in;
    cap = 1'b1;
    cyc();
    cap = 1'b0;
    pulse_update();
    mode = 2'b01;
    cyc();
    @(negedge clk);
    check(bus_o === bus_of(pat_a), "R9 update ignored", 32'(bus_o), 32'(bus_of(pat_a)));
    cyc();
    sel = 1'b1;
    xchg(pat_b, rd);
    check(rd === ecap, "R7 R9 captured chain", 32'(rd), 32'(ecap));
    @(negedge clk);
    summary();
  end
endmodule